// File: doc/BRIEF.md
# Interrupt Destination Acceptance Filter

This block sits on the receiving side of an interrupt controller. Every incoming interrupt message carries a destination byte, a physical/logical mode bit, a two-bit shorthand code and the ID of the controller that issued it. The filter decides, one clock after the message is presented, whether this controller is one of the targets.

The filter keeps three programmable registers, all written through a simple register port. The physical ID register holds the controller's own ID. The logical destination register holds a separate logical ID. The format register selects how logical destinations are read. A logical destination is read either as a flat 8-bit member mask or as a cluster number plus a 4-bit member mask. Physical messages compare the destination against the physical ID. The shorthand codes override addressing for self-only, all-including-self and all-excluding-self messages.

Top module: `irq_dest_filter`

## Requirements
- R1: With shorthand 00 and the mode bit at 0 (physical), a message is accepted when its destination equals the physical ID register. It is rejected when the two differ, unless the destination is FFh.
- R2: A physical-mode destination of FFh (shorthand 00) is accepted whatever the physical ID.
- R3: With shorthand 00, the mode bit at 1 (logical) and the flat model selected, a message is accepted exactly when the bitwise AND of the destination and the logical ID is non-zero.
- R4: With shorthand 00, logical mode and the cluster model selected, a message is accepted only when destination bits 7:4 equal logical ID bits 7:4 and the AND of destination bits 3:0 with logical ID bits 3:0 is non-zero.
- R5: In the cluster model, a destination of FFh is accepted whatever the logical ID. Any other destination whose upper nibble is Fh obeys R4.
- R6: A model value of 0000b in format bits 31:28 selects the cluster model, and every other value selects the flat model. The model has no effect on physical-mode messages.
- R7: Shorthand 01 (self) is accepted exactly when the source ID equals the physical ID. Destination and mode bit are ignored.
- R8: Shorthand 10 (all including self) is always accepted.
- R9: Shorthand 11 (all excluding self) is accepted exactly when the source ID differs from the physical ID.
- R10: Logical matching uses only the logical ID, and physical matching uses only the physical ID. Neither register stands in for the other.
- R11: Register select 0 is the physical ID, held in bits 7:0. Select 1 is the logical destination register, with the logical ID in bits 31:24. Select 2 is the format register, with the model in bits 31:28. Select 3 reads zero. All unused bits read zero. After reset the registers read 0, 0 and F0000000h.
- R12: The accept valid output is high exactly one cycle after each cycle in which message valid is high. The accept output is never high while the accept valid output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and read |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_sel (combinational) |
| msg_valid | input | 1 | Incoming message present this cycle |
| msg_dest | input | 8 | Message destination byte |
| msg_logical | input | 1 | 1 = logical destination mode, 0 = physical |
| msg_short | input | 2 | Shorthand: 00 none, 01 self, 10 all incl. self, 11 all excl. self |
| msg_src_id | input | 8 | Physical ID of the issuing controller |
| acc_valid | output | 1 | Decision valid, one cycle after msg_valid |
| acc_hit | output | 1 | Message accepted by this controller |

## Verification
The assertions assume that the message fields carry known values whenever msg_valid is high. They also assume that a decision depends only on the register contents that were in force in the cycle the message was presented. The stimulus meets both assumptions. It drives every input on the falling edge and keeps each field defined. It also never writes a register in the same cycle as a message whose expected result depends on that write. Messages are sometimes presented back to back and sometimes separated by idle cycles, so the one-cycle valid pipeline is exercised in both patterns.

// File: rtl/irq_dest_filter.sv
module irq_dest_filter #(
  parameter int DW = 8,
  parameter int RW = 32,
  parameter int MW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [1:0]    cfg_sel,
  input  logic [RW-1:0] cfg_wdata,
  output logic [RW-1:0] cfg_rdata,
  input  logic          msg_valid,
  input  logic [DW-1:0] msg_dest,
  input  logic          msg_logical,
  input  logic [1:0]    msg_short,
  input  logic [DW-1:0] msg_src_id,
  output logic          acc_valid,
  output logic          acc_hit
);
  localparam int NIB = DW / 2;
  localparam logic [MW-1:0] CLUSTER = '0;

  logic [DW-1:0] id_q, lid_q;
  logic [MW-1:0] model_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_q    <= '0;
      lid_q   <= '0;
      model_q <= '1;
    end else if (cfg_we) begin
      case (cfg_sel)
        2'd0: id_q    <= cfg_wdata[DW-1:0];
        2'd1: lid_q   <= cfg_wdata[RW-1 -: DW];
        2'd2: model_q <= cfg_wdata[RW-1 -: MW];
        default: ;
      endcase
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      2'd0: cfg_rdata[DW-1:0]    = id_q;
      2'd1: cfg_rdata[RW-1 -: DW] = lid_q;
      2'd2: cfg_rdata[RW-1 -: MW] = model_q;
      default: ;
    endcase
  end

  wire all_ones  = &msg_dest;
  wire phys_hit  = (msg_dest == id_q) || all_ones;
  wire flat_hit  = |(msg_dest & lid_q);
  wire clus_hit  = all_ones ||
                   ((msg_dest[DW-1:NIB] == lid_q[DW-1:NIB]) &&
                    |(msg_dest[NIB-1:0] & lid_q[NIB-1:0]));
  wire log_hit   = (model_q == CLUSTER) ? clus_hit : flat_hit;
  wire dest_hit  = msg_logical ? log_hit : phys_hit;
  wire is_self   = (msg_src_id == id_q);

  logic hit_d;
  always_comb begin
    case (msg_short)
      2'b01:   hit_d = is_self;
      2'b10:   hit_d = 1'b1;
      2'b11:   hit_d = !is_self;
      default: hit_d = dest_hit;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_hit   <= 1'b0;
    end else begin
      acc_valid <= msg_valid;
      acc_hit   <= msg_valid && hit_d;
    end
  end
endmodule

// File: rtl/irq_dest_filter_chk.sv
module irq_dest_filter_chk #(
  parameter int DW = 8,
  parameter int MW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          msg_valid,
  input logic [DW-1:0] msg_dest,
  input logic          msg_logical,
  input logic [1:0]    msg_short,
  input logic [DW-1:0] msg_src_id,
  input logic          acc_valid,
  input logic          acc_hit,
  input logic [DW-1:0] id_q,
  input logic [DW-1:0] lid_q,
  input logic [MW-1:0] model_q
);
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |=> acc_valid);
  a_r12_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_valid |=> !acc_valid);
  a_r12_hit_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !acc_hit);
  a_r1_phys_match: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b00 && !msg_logical && msg_dest == id_q) |=> acc_hit);
  a_r3_flat_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b00 && msg_logical && model_q != '0 &&
     (msg_dest & lid_q) == '0) |=> !acc_hit);
  a_r7_self_only: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b01 && msg_src_id != id_q) |=> !acc_hit);
  a_r8_all_incl: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b10) |=> acc_hit);
  a_r9_excl_self: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_short == 2'b11 && msg_src_id == id_q) |=> !acc_hit);
endmodule

bind irq_dest_filter irq_dest_filter_chk u_chk (.*);

// File: tb/irq_dest_filter_tb_top.sv
`timescale 1ns/1ps
module irq_dest_filter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic msg_valid = 1'b0;
  logic [7:0] msg_dest = '0;
  logic msg_logical = 1'b0;
  logic [1:0] msg_short = '0;
  logic [7:0] msg_src_id = '0;
  logic acc_valid, acc_hit;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irq_dest_filter dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .msg_valid(msg_valid),
    .msg_dest(msg_dest), .msg_logical(msg_logical), .msg_short(msg_short),
    .msg_src_id(msg_src_id), .acc_valid(acc_valid), .acc_hit(acc_hit)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    msg_valid = 1'b0;
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    msg_valid = 1'b0;
    cfg_sel = sel;
    #1 check(tag, cfg_rdata, exp);
  endtask

  task automatic send(input logic [7:0] d, input logic lg, input logic [1:0] sh,
                      input logic [7:0] src, input bit exp, input string tag);
    @(negedge clk);
    msg_valid = 1'b1; msg_dest = d; msg_logical = lg;
    msg_short = sh; msg_src_id = src;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      msg_valid = 1'b0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && acc_valid) begin
      if (exp_q.size() == 0) check("R12 unexpected acc_valid", 1, 0);
      else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {31'd0, acc_hit}, {31'd0, e});
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R12 reset acc_valid", {31'd0, acc_valid}, 0);
    rd(2'd0, 32'h0, "R11 reset phys id");
    rd(2'd1, 32'h0, "R11 reset logical reg");
    rd(2'd2, 32'hF000_0000, "R11 reset format");
    rd(2'd3, 32'h0, "R11 unused select");

    wr(2'd0, 32'hFFFF_FF42);
    wr(2'd1, 32'h35AB_CDEF);
    rd(2'd0, 32'h0000_0042, "R11 phys id readback");
    rd(2'd1, 32'h3500_0000, "R11 logical readback");

    send(8'h42, 0, 2'b00, 8'h00, 1, "R1 phys equal");
    send(8'h43, 0, 2'b00, 8'h00, 0, "R1 phys differ");
    send(8'hFF, 0, 2'b00, 8'h00, 1, "R2 phys broadcast");
    send(8'h35, 0, 2'b00, 8'h00, 0, "R10 phys ignores logical id");
    idle(2);
    send(8'h04, 1, 2'b00, 8'h00, 1, "R3 flat overlap");
    send(8'h0A, 1, 2'b00, 8'h00, 0, "R3 flat no overlap");
    send(8'h42, 1, 2'b00, 8'h00, 0, "R10 logical ignores phys id");
    idle(3);

    wr(2'd2, 32'h0FFF_FFFF);
    rd(2'd2, 32'h0, "R11 format cluster readback");
    send(8'h31, 1, 2'b00, 8'h00, 1, "R4 cluster member hit");
    send(8'h32, 1, 2'b00, 8'h00, 0, "R4 cluster member miss");
    send(8'h41, 1, 2'b00, 8'h00, 0, "R4 cluster id mismatch");
    send(8'h05, 1, 2'b00, 8'h00, 0, "R6 cluster model rejects flat hit");
    send(8'hFF, 1, 2'b00, 8'h00, 1, "R5 cluster all ones");
    send(8'hF5, 1, 2'b00, 8'h00, 0, "R5 cluster Fh not all ones");
    send(8'h42, 0, 2'b00, 8'h00, 1, "R6 phys unaffected by model");
    idle(2);

    wr(2'd2, 32'h7000_0000);
    rd(2'd2, 32'h7000_0000, "R11 format other readback");
    send(8'h05, 1, 2'b00, 8'h00, 1, "R6 other model is flat");
    idle(1);

    send(8'h00, 0, 2'b01, 8'h42, 1, "R7 self from self");
    send(8'h42, 0, 2'b01, 8'h41, 0, "R7 self from other");
    send(8'h00, 1, 2'b10, 8'h11, 1, "R8 all incl self");
    send(8'h42, 0, 2'b11, 8'h42, 0, "R9 excl self from self");
    send(8'h00, 0, 2'b11, 8'h07, 1, "R9 excl self from other");
    idle(4);
    check("R12 all results seen", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule